// File: doc/BRIEF.md
# Block-Averaging Oversampler with Resolution Boost

This block takes the stream of signed 16-bit conversion results from a single converter channel and reduces it by block averaging. It sums a fresh, non-overlapping group of N accepted samples and emits one result per group. N is a power of two from 1 to 32, chosen by a small select field. An accepted sample is one presented while the sample strobe is high.

When N is greater than 1, the block also delivers two extra low-order bits, so each result is an 18-bit two's-complement value equal to four times the group mean, truncated toward minus infinity. With N equal to 1, averaging is off: each sample passes straight through, sign-extended onto the 18-bit result bus, and the boost flag stays low. Downstream logic uses the boost flag to tell whether the word carries 16 or 18 significant bits. It should hold the boosted word in a 32-bit container.

The ratio may be changed at any time. The block drops any partially summed group and starts counting again under the new ratio, so no result ever mixes two ratios.

Top module: `boost_averager`

## Requirements
- R1: `ratioSel` value k in 0..5 selects a group size of N = 2^k samples. The values 6 and 7 behave exactly like 5 (N = 32).
- R2: A result is produced once for every N accepted samples, and each group is disjoint from the one before it. Cycles with `sampleValid` low do not count toward the group and do not change the sum.
- R3: `resultValid` is high for exactly the one cycle that follows the clock edge accepting the Nth sample of a group, and is never high in any other cycle.
- R4: With N > 1, `resultData` equals floor(4 * S / N) as an 18-bit two's-complement value, where S is the signed sum of the group's samples.
- R5: With N = 1, `resultData` is the accepted sample sign-extended from 16 to 18 bits, and it is produced after every accepted sample.
- R6: `boostOn` is updated together with each result. It is 1 when that result was formed with N > 1 and 0 when it was formed with N = 1.
- R7: If `ratioSel` changes while a group is partly summed, the partial sum is dropped. The sample accepted in the cycle of the change, if any, becomes the first sample of a new group under the new ratio.
- R8: A group of 32 full-scale samples does not overflow: 32 samples of -32768 yield -131072, and 32 samples of 32767 yield 131068.
- R9: During and right after reset, `resultValid`, `resultData` and `boostOn` are 0 and no samples are held.
- R10: Between results, `resultData` and `boostOn` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | High when `sampleData` carries a sample to accept |
| sampleData | input | 16 | Signed conversion result |
| ratioSel | input | 3 | log2 of the group size (0 = averaging off) |
| resultData | output | 18 | Signed result: sign-extended sample or boosted mean |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| boostOn | output | 1 | Result carries the two extra bits |

## Verification
The assertions check four properties on every cycle:
- a result strobe is always preceded by an accepted sample;
- an unboosted result equals the sign-extended previous sample;
- the boost flag matches the ratio that was selected when the final sample arrived;
- the result word and the flag stay steady between strobes.

Group counting across idle cycles, the arithmetic of the boosted mean (including the floor on negative sums and full-scale sums of 32), the clamping of out-of-range select values, and dropping a partial group on a ratio change can only be shown by the bench's directed scenarios, which compare against sums they compute themselves.

// File: rtl/boost_avg_pkg.sv
package boost_avg_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             take;   // sample accepted this cycle
    logic             start;  // sample is first of a group
    logic             emit;   // sample is last of a group
    logic [SEL_W-1:0] log2n;  // group size exponent in force
  } avgCtrl_t;
endpackage

// File: rtl/boost_avg_ctrl.sv
module boost_avg_ctrl
  import boost_avg_pkg::*;
#(
  parameter int MAX_LOG = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [SEL_W-1:0] ratioSel,
  output avgCtrl_t         ctl
);
  localparam int CNT_W = MAX_LOG;

  logic [SEL_W-1:0] activeLog, reqLog, effLog;
  logic [CNT_W-1:0] cnt, effCnt, lastIdx;
  logic             changed;

  always_comb begin
    reqLog  = (ratioSel > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : ratioSel;
    changed = (reqLog != activeLog);
    effLog  = reqLog;
    effCnt  = changed ? '0 : cnt;
    lastIdx = CNT_W'((32'd1 << effLog) - 32'd1);
    ctl.take  = sampleValid;
    ctl.start = sampleValid && (effCnt == '0);
    ctl.emit  = sampleValid && (effCnt == lastIdx);
    ctl.log2n = effLog;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeLog <= '0;
      cnt       <= '0;
    end else begin
      activeLog <= reqLog;
      if (sampleValid) cnt <= ctl.emit ? '0 : effCnt + CNT_W'(1);
      else             cnt <= effCnt;
    end
  end
endmodule

// File: rtl/boost_avg_datapath.sv
module boost_avg_datapath
  import boost_avg_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int MAX_LOG    = 5,
  parameter int BOOST_BITS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  avgCtrl_t            ctl,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [SAMPLE_W+BOOST_BITS-1:0] resultData,
  output logic                resultValid,
  output logic                boostOn
);
  localparam int ACC_W  = SAMPLE_W + MAX_LOG;
  localparam int WIDE_W = ACC_W + BOOST_BITS;
  localparam int OUT_W  = SAMPLE_W + BOOST_BITS;

  logic signed [ACC_W-1:0]  acc, extSample, sum;
  logic signed [WIDE_W-1:0] wideSum;
  logic [OUT_W-1:0]         plainWord, boostedWord;

  always_comb begin
    extSample   = {{(ACC_W-SAMPLE_W){sampleData[SAMPLE_W-1]}}, sampleData};
    sum         = ctl.start ? extSample : acc + extSample;
    wideSum     = {sum, {BOOST_BITS{1'b0}}};
    boostedWord = OUT_W'(wideSum >>> ctl.log2n);
    plainWord   = {{BOOST_BITS{sampleData[SAMPLE_W-1]}}, sampleData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc         <= '0;
      resultData  <= '0;
      resultValid <= 1'b0;
      boostOn     <= 1'b0;
    end else begin
      resultValid <= ctl.emit;
      if (ctl.take) acc <= sum;
      if (ctl.emit) begin
        resultData <= (ctl.log2n == '0) ? plainWord : boostedWord;
        boostOn    <= (ctl.log2n != '0);
      end
    end
  end
endmodule

// File: rtl/boost_averager.sv
module boost_averager
  import boost_avg_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int MAX_LOG    = 5,
  parameter int BOOST_BITS = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           sampleValid,
  input  logic [SAMPLE_W-1:0]            sampleData,
  input  logic [SEL_W-1:0]               ratioSel,
  output logic [SAMPLE_W+BOOST_BITS-1:0] resultData,
  output logic                           resultValid,
  output logic                           boostOn
);
  avgCtrl_t ctl;

  boost_avg_ctrl #(.MAX_LOG(MAX_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .ratioSel(ratioSel), .ctl(ctl)
  );

  boost_avg_datapath #(
    .SAMPLE_W(SAMPLE_W), .MAX_LOG(MAX_LOG), .BOOST_BITS(BOOST_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleData(sampleData),
    .resultData(resultData), .resultValid(resultValid), .boostOn(boostOn)
  );
endmodule

// File: rtl/boost_averager_chk.sv
module boost_averager_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sampleValid,
  input logic [15:0] sampleData,
  input logic [2:0]  ratioSel,
  input logic [17:0] resultData,
  input logic        resultValid,
  input logic        boostOn
);
  // R3
  strobe_after_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(sampleValid));

  // R5
  passthrough_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !boostOn) |->
      (resultData == {{2{$past(sampleData[15])}}, $past(sampleData)}));

  // R6
  boost_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (boostOn == ($past(ratioSel) != 3'd0)));

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(resultData) && $stable(boostOn)));
endmodule

bind boost_averager boost_averager_chk u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
  .ratioSel(ratioSel), .resultData(resultData), .resultValid(resultValid),
  .boostOn(boostOn)
);

// File: tb/sim_boost_averager.sv
module sim_boost_averager;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic [2:0]  ratioSel = '0;
  logic [17:0] resultData;
  logic        resultValid;
  logic        boostOn;

  int nTests = 0;
  int nFail  = 0;
  logic gotV;
  int   gotD;
  logic gotB;

  always #4 clk = ~clk;

  boost_averager u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .ratioSel(ratioSel), .resultData(resultData), .resultValid(resultValid),
    .boostOn(boostOn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expBoost(input longint s, input int k);
    return int'((s * 4) >>> k);
  endfunction

  // drive one sample (and optionally a new ratio) and capture the cycle after
  task automatic sendSel(input int v, input int sel);
    @(negedge clk);
    ratioSel    = 3'(sel);
    sampleValid = 1'b1;
    sampleData  = 16'(v);
    @(negedge clk);
    sampleValid = 1'b0;
    gotV = resultValid;
    gotD = int'($signed(resultData));
    gotB = boostOn;
  endtask

  task automatic send(input int v);
    sendSel(v, int'(ratioSel));
  endtask

  task automatic setRatio(input int sel);
    @(negedge clk);
    ratioSel = 3'(sel);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R9 valid", int'(resultValid), 0);
    chk("R9 data", int'(resultData), 0);
    chk("R9 boost", int'(boostOn), 0);
  endtask

  task automatic testPassthrough();
    setRatio(0);
    send(1234);
    chk("R5 valid", int'(gotV), 1);
    chk("R5 data", gotD, 1234);
    chk("R6 boost off", int'(gotB), 0);
    send(-5);
    chk("R5 negative", gotD, -5);
    chk("R3 strobe", int'(gotV), 1);
  endtask

  task automatic testAvg4Gaps();
    longint s = 0;
    int vals[4] = '{100, -200, 300, 401};
    setRatio(2);
    for (int i = 0; i < 4; i++) begin
      send(vals[i]);
      s += vals[i];
      if (i < 3) begin
        chk("R3 no early strobe", int'(gotV), 0);
        idle(2);
        chk("R2 idle no strobe", int'(resultValid), 0);
      end
    end
    chk("R2 strobe at N", int'(gotV), 1);
    chk("R4 mean N=4", gotD, expBoost(s, 2));
    chk("R6 boost on", int'(gotB), 1);
    @(negedge clk);
    chk("R3 single pulse", int'(resultValid), 0);
    idle(4);
    chk("R10 hold data", int'($signed(resultData)), expBoost(s, 2));
    chk("R10 hold flag", int'(boostOn), 1);
  endtask

  task automatic testAvg2();
    setRatio(1);
    send(7);
    chk("R3 N=2 first", int'(gotV), 0);
    send(8);
    chk("R4 N=2", gotD, 30);
  endtask

  task automatic testFloor();
    setRatio(3);
    for (int i = 0; i < 8; i++) send(i == 0 ? -1 : 0);
    chk("R4 floor negative", gotD, -1);
    chk("R2 N=8 strobe", int'(gotV), 1);
  endtask

  task automatic testChange();
    setRatio(3);
    for (int i = 0; i < 3; i++) send(1000);
    sendSel(10, 1);
    chk("R7 no strobe at change", int'(gotV), 0);
    send(20);
    chk("R7 strobe new ratio", int'(gotV), 1);
    chk("R7 fresh sum", gotD, 60);
  endtask

  task automatic testFullScale();
    setRatio(7);
    for (int i = 0; i < 32; i++) begin
      send(-32768);
      if (i == 30) chk("R1 clamp no strobe at 31", int'(gotV), 0);
    end
    chk("R1 clamp strobe at 32", int'(gotV), 1);
    chk("R8 negative full scale", gotD, -131072);
    setRatio(5);
    for (int i = 0; i < 32; i++) send(32767);
    chk("R8 positive full scale", gotD, 131068);
    chk("R6 boost N=32", int'(gotB), 1);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    idle(3);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPassthrough();
    testAvg4Gaps();
    testAvg2();
    testFloor();
    testChange();
    testFullScale();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule